// File: doc/BRIEF.md
# Interrupt and Non-Maskable Fault Request Arbiter

This block sits between a core's interrupt lines, its data-bus fault signals and its trap entry logic. It builds a pending mask from 32 level-sensitive interrupt lines and turns it into a single request. Each line is counted only if it is a usable line, its own enable bit is set and the global enable is set. The block also captures data-bus faults and parity faults as non-maskable requests. It presents one registered request per cycle: a valid flag and an 8-bit cause code.

Non-maskable requests always win over regular lines. The global enable never masks them. Debug mode masks them, and so does single-stepping with the step-interrupt enable cleared. Only the first fault is kept until the trap logic acknowledges it. The trap logic acknowledges the request it has accepted by pulsing `trapTaken` while that request is on the outputs. A separate status flag shows that a non-maskable request is waiting.

Top module: `trap_request_arbiter`

## Requirements
- R1: Only lines 31..16, 11, 7 and 3 can produce a request. Lines 10:8, 6:4 and 2:0 never produce one, whatever their level and enable bits.
- R2: A regular line produces a request only while the line is high, its bit in `irqEnable` is set and `globalEnable` is 1. After reset, `reqValid` is 0 and `nmiPending` is 0.
- R3: Among enabled regular lines the priority runs as follows: lines 31 down to 16 with the higher number winning, then 11, then 3, and 7 last. `reqCode` is the line number.
- R4: A bus fault is recorded when `dataErr` and `dataRvalid` are both 1. `accessIsStore` selects the code: 128 for a load, 129 for a store. A load parity fault gives 130 and a store parity fault gives 131. `dataErr` without `dataRvalid` records nothing.
- R5: A visible non-maskable request always takes precedence over any regular line, and `globalEnable` = 0 does not mask it.
- R6: While `debugMode` is 1, no request is presented. A non-maskable request held back by debug mode appears on the outputs one cycle after `debugMode` falls.
- R7: While `singleStep` is 1 and `stepIrqEnable` is 0, non-maskable requests are masked but regular lines are not. With `stepIrqEnable` = 1 they are presented.
- R8: While a non-maskable request is pending, further faults are discarded and the reported code stays that of the first fault.
- R9: `trapTaken` while a non-maskable request is presented clears it. The output drops in the next cycle. A fault arriving in the acknowledge cycle is latched, and its request appears one cycle later.
- R10: Outputs are registered. A change on the regular lines shows one cycle later, and a fault pulse raises `reqValid` two cycles later.
- R11: `nmiPending` rises one cycle after a fault pulse. It stays 1, even while masked, until an acknowledge clears it.
- R12: Faults in the same cycle are resolved by code: the highest of 131, 130, 129 and 128 is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqLines | input | 32 | Level-sensitive interrupt lines |
| irqEnable | input | 32 | Per-line enable mask |
| globalEnable | input | 1 | Global enable for regular lines |
| debugMode | input | 1 | Core is in debug mode |
| singleStep | input | 1 | Core is single-stepping |
| stepIrqEnable | input | 1 | Allow requests while single-stepping |
| dataErr | input | 1 | Data bus error response |
| dataRvalid | input | 1 | Data bus response valid |
| accessIsStore | input | 1 | The faulting access is a store (1) or a load (0) |
| loadParityFault | input | 1 | Load parity or checksum fault pulse |
| storeParityFault | input | 1 | Store parity or checksum fault pulse |
| trapTaken | input | 1 | The presented request has been taken |
| reqValid | output | 1 | A request is presented |
| reqCode | output | 8 | Line number or non-maskable cause code |
| nmiPending | output | 1 | A non-maskable request is latched |

## Verification
Each gating input is cleared in turn: the line enable, the global enable and the usable-line mask. This shows that each one alone suppresses a request. Line sets that mix custom and standard lines separate the numeric ordering of the custom range from the reordered 11, 3, 7 tail. Fault pulses are applied one at a time, then back to back, then together, and together with an acknowledge. Together these cases separate the code mapping, the first-fault hold, the simultaneous resolution and the acknowledge-cycle relatch. The debug and single-step windows show masking, and that a request held back stays pending.

// File: rtl/tra_pkg.sv
package tra_pkg;
  localparam int LINES      = 32;
  localparam int CODE_W     = 8;
  localparam int CUSTOM_LO  = 16;
  localparam int LINE_EXT   = 11;
  localparam int LINE_SOFT  = 3;
  localparam int LINE_TIMER = 7;
  localparam int NMI_BASE   = 128;
  localparam logic [LINES-1:0] USABLE =
    ({LINES{1'b1}} << CUSTOM_LO) | (LINES'(1) << LINE_EXT) |
    (LINES'(1) << LINE_SOFT) | (LINES'(1) << LINE_TIMER);

  typedef enum logic [1:0] {
    FAULT_LD_BUS  = 2'd0,
    FAULT_ST_BUS  = 2'd1,
    FAULT_LD_PAR  = 2'd2,
    FAULT_ST_PAR  = 2'd3
  } faultKind_t;

  typedef struct packed {
    logic       nmiVisible;
    faultKind_t nmiKind;
    logic       regularAllowed;
  } ctrlStrobes_t;
endpackage

// File: rtl/tra_ctrl.sv
module tra_ctrl
  import tra_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         globalEnable,
  input  logic         debugMode,
  input  logic         singleStep,
  input  logic         stepIrqEnable,
  input  logic         dataErr,
  input  logic         dataRvalid,
  input  logic         accessIsStore,
  input  logic         loadParityFault,
  input  logic         storeParityFault,
  input  logic         trapTaken,
  output ctrlStrobes_t strobes,
  output logic         nmiPending
);
  logic       pendingQ;
  faultKind_t kindQ;
  logic       shownQ;
  logic       busFault;
  logic       faultAny;
  faultKind_t faultKind;
  logic       nmiAck;
  logic       canLatch;
  logic       nmiLive;
  logic       nmiMasked;

  assign busFault = dataErr && dataRvalid;
  assign faultAny = busFault || loadParityFault || storeParityFault;

  // Highest code wins when several faults arrive together.
  always_comb begin
    if (storeParityFault)            faultKind = FAULT_ST_PAR;
    else if (loadParityFault)        faultKind = FAULT_LD_PAR;
    else if (busFault && accessIsStore) faultKind = FAULT_ST_BUS;
    else                             faultKind = FAULT_LD_BUS;
  end

  assign nmiAck    = trapTaken && shownQ;
  assign canLatch  = !pendingQ || nmiAck;
  assign nmiLive   = pendingQ && !nmiAck;
  assign nmiMasked = debugMode || (singleStep && !stepIrqEnable);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
      kindQ    <= FAULT_LD_BUS;
      shownQ   <= 1'b0;
    end else begin
      if (canLatch) begin
        pendingQ <= faultAny;
        if (faultAny) kindQ <= faultKind;
      end
      shownQ <= nmiLive && !nmiMasked;
    end
  end

  assign strobes.nmiVisible     = nmiLive && !nmiMasked;
  assign strobes.nmiKind        = kindQ;
  assign strobes.regularAllowed = globalEnable && !debugMode;
  assign nmiPending             = pendingQ;
endmodule

// File: rtl/tra_datapath.sv
module tra_datapath
  import tra_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  irqLines,
  input  logic [LINES-1:0]  irqEnable,
  input  ctrlStrobes_t      strobes,
  output logic              reqValid,
  output logic [CODE_W-1:0] reqCode
);
  logic [LINES-1:0]  pendingMask;
  logic [LINES-1:0]  armed;
  logic              customHit;
  logic [CODE_W-1:0] customCode;
  logic              regularHit;
  logic [CODE_W-1:0] regularCode;
  logic              nextValid;
  logic [CODE_W-1:0] nextCode;

  assign pendingMask = irqLines & USABLE;
  assign armed       = pendingMask & irqEnable;

  // Ascending scan: the last hit, i.e. the highest line, is kept.
  always_comb begin
    customHit  = 1'b0;
    customCode = '0;
    for (int i = CUSTOM_LO; i < LINES; i++) begin
      if (armed[i]) begin
        customHit  = 1'b1;
        customCode = CODE_W'(i);
      end
    end
  end

  always_comb begin
    regularHit  = 1'b1;
    regularCode = customCode;
    if (!customHit) begin
      if (armed[LINE_EXT])        regularCode = CODE_W'(LINE_EXT);
      else if (armed[LINE_SOFT])  regularCode = CODE_W'(LINE_SOFT);
      else if (armed[LINE_TIMER]) regularCode = CODE_W'(LINE_TIMER);
      else                        regularHit  = 1'b0;
    end
  end

  always_comb begin
    if (strobes.nmiVisible) begin
      nextValid = 1'b1;
      nextCode  = CODE_W'(NMI_BASE) + CODE_W'(strobes.nmiKind);
    end else if (strobes.regularAllowed && regularHit) begin
      nextValid = 1'b1;
      nextCode  = regularCode;
    end else begin
      nextValid = 1'b0;
      nextCode  = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      reqCode  <= '0;
    end else begin
      reqValid <= nextValid;
      reqCode  <= nextCode;
    end
  end
endmodule

// File: rtl/trap_request_arbiter.sv
module trap_request_arbiter
  import tra_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  irqLines,
  input  logic [LINES-1:0]  irqEnable,
  input  logic              globalEnable,
  input  logic              debugMode,
  input  logic              singleStep,
  input  logic              stepIrqEnable,
  input  logic              dataErr,
  input  logic              dataRvalid,
  input  logic              accessIsStore,
  input  logic              loadParityFault,
  input  logic              storeParityFault,
  input  logic              trapTaken,
  output logic              reqValid,
  output logic [CODE_W-1:0] reqCode,
  output logic              nmiPending
);
  ctrlStrobes_t strobes;

  tra_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .globalEnable(globalEnable), .debugMode(debugMode),
    .singleStep(singleStep), .stepIrqEnable(stepIrqEnable),
    .dataErr(dataErr), .dataRvalid(dataRvalid), .accessIsStore(accessIsStore),
    .loadParityFault(loadParityFault), .storeParityFault(storeParityFault),
    .trapTaken(trapTaken), .strobes(strobes), .nmiPending(nmiPending)
  );

  tra_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .irqLines(irqLines), .irqEnable(irqEnable),
    .strobes(strobes), .reqValid(reqValid), .reqCode(reqCode)
  );
endmodule

// File: rtl/tra_checker.sv
module tra_checker (
  input logic       clk,
  input logic       rstN,
  input logic       globalEnable,
  input logic       debugMode,
  input logic       singleStep,
  input logic       stepIrqEnable,
  input logic       trapTaken,
  input logic       reqValid,
  input logic [7:0] reqCode,
  input logic       nmiPending
);
  // R1: only usable line numbers or fault codes appear
  a_r1_usable_code: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqCode[7] || reqCode >= 8'd16 || reqCode == 8'd11 ||
                  reqCode == 8'd7 || reqCode == 8'd3));
  // R2: no regular request without the global enable
  a_r2_global_gate: assert property (@(posedge clk) disable iff (!rstN)
    !globalEnable |=> !(reqValid && !reqCode[7]));
  // R4: fault codes stay in 128..131
  a_r4_code_range: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCode[7]) |-> (reqCode <= 8'd131));
  // R5: an unmasked pending fault is presented next cycle
  a_r5_nmi_first: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPending && !trapTaken && !debugMode && !(singleStep && !stepIrqEnable))
      |=> (reqValid && reqCode[7]));
  // R6: debug mode blocks every request
  a_r6_debug_mask: assert property (@(posedge clk) disable iff (!rstN)
    debugMode |=> !reqValid);
  // R8: the presented fault code does not change while pending
  a_r8_code_held: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCode[7] && !trapTaken && !debugMode && !(singleStep && !stepIrqEnable))
      |=> (reqCode == $past(reqCode)));
  // R11: the pending flag holds until acknowledged
  a_r11_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPending && !trapTaken) |=> nmiPending);
endmodule

bind trap_request_arbiter tra_checker u_chk (
  .clk(clk), .rstN(rstN), .globalEnable(globalEnable), .debugMode(debugMode),
  .singleStep(singleStep), .stepIrqEnable(stepIrqEnable), .trapTaken(trapTaken),
  .reqValid(reqValid), .reqCode(reqCode), .nmiPending(nmiPending)
);

// File: tb/sim_trap_request_arbiter.sv
`timescale 1ns/1ps
module sim_trap_request_arbiter;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] irqLines, irqEnable;
  logic        globalEnable, debugMode, singleStep, stepIrqEnable;
  logic        dataErr, dataRvalid, accessIsStore;
  logic        loadParityFault, storeParityFault, trapTaken;
  logic        reqValid;
  logic [7:0]  reqCode;
  logic        nmiPending;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  trap_request_arbiter u0 (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .irqEnable(irqEnable),
    .globalEnable(globalEnable), .debugMode(debugMode), .singleStep(singleStep),
    .stepIrqEnable(stepIrqEnable), .dataErr(dataErr), .dataRvalid(dataRvalid),
    .accessIsStore(accessIsStore), .loadParityFault(loadParityFault),
    .storeParityFault(storeParityFault), .trapTaken(trapTaken),
    .reqValid(reqValid), .reqCode(reqCode), .nmiPending(nmiPending)
  );

  task automatic chk(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    irqLines = '0; irqEnable = '0; globalEnable = 1'b0;
    debugMode = 1'b0; singleStep = 1'b0; stepIrqEnable = 1'b0;
    dataErr = 1'b0; dataRvalid = 1'b0; accessIsStore = 1'b0;
    loadParityFault = 1'b0; storeParityFault = 1'b0; trapTaken = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  // kind: 0 load bus, 1 store bus, 2 load parity, 3 store parity; one edge
  task automatic pulseFault(int kind);
    case (kind)
      0: begin dataErr = 1'b1; dataRvalid = 1'b1; accessIsStore = 1'b0; end
      1: begin dataErr = 1'b1; dataRvalid = 1'b1; accessIsStore = 1'b1; end
      2: loadParityFault = 1'b1;
      default: storeParityFault = 1'b1;
    endcase
    step(1);
    dataErr = 1'b0; dataRvalid = 1'b0; accessIsStore = 1'b0;
    loadParityFault = 1'b0; storeParityFault = 1'b0;
  endtask

  task automatic tResetState();
    doReset();
    chk("R2 reset reqValid", int'(reqValid), 0);
    chk("R2 reset nmiPending", int'(nmiPending), 0);
  endtask

  task automatic tGating();
    doReset();
    irqLines = 32'h0000_0800; irqEnable = 32'h0; globalEnable = 1'b1;
    step(1);
    chk("R2 line enable off", int'(reqValid), 0);
    irqEnable = 32'h0000_0800; globalEnable = 1'b0;
    step(1);
    chk("R2 global off", int'(reqValid), 0);
    globalEnable = 1'b1;
    #1 chk("R10 not before edge", int'(reqValid), 0);
    step(1);
    chk("R2 both set valid", int'(reqValid), 1);
    chk("R2 both set code", int'(reqCode), 11);
    irqLines = 32'h0;
    step(1);
    chk("R10 line drop follows", int'(reqValid), 0);
  endtask

  task automatic tReserved();
    doReset();
    irqLines = 32'h0000_0777; irqEnable = 32'hFFFF_FFFF; globalEnable = 1'b1;
    step(2);
    chk("R1 reserved lines ignored", int'(reqValid), 0);
  endtask

  task automatic tPriority();
    doReset();
    irqEnable = 32'hFFFF_FFFF; globalEnable = 1'b1;
    irqLines = 32'hFFFF_FFFF; step(1);
    chk("R3 all lines", int'(reqCode), 31);
    irqLines = 32'h0012_0000; step(1);
    chk("R3 custom 20 over 17", int'(reqCode), 20);
    irqLines = 32'h0001_0888; step(1);
    chk("R3 custom over standard", int'(reqCode), 16);
    irqLines = 32'h0000_0888; step(1);
    chk("R3 ext first", int'(reqCode), 11);
    irqLines = 32'h0000_0088; step(1);
    chk("R3 soft over timer", int'(reqCode), 3);
    irqLines = 32'h0000_0080; step(1);
    chk("R3 timer alone valid", int'(reqValid), 1);
    chk("R3 timer alone code", int'(reqCode), 7);
  endtask

  task automatic tNmiCodes();
    for (int k = 0; k < 4; k++) begin
      doReset();
      pulseFault(k);
      chk("R11 flag after one cycle", int'(nmiPending), 1);
      chk("R10 valid not yet", int'(reqValid), 0);
      step(1);
      chk("R4 fault valid", int'(reqValid), 1);
      chk("R4 fault code", int'(reqCode), 128 + k);
    end
    doReset();
    dataErr = 1'b1; step(1); dataErr = 1'b0; step(1);
    chk("R4 error without rvalid", int'(nmiPending), 0);
  endtask

  task automatic tNmiOverRegular();
    doReset();
    irqLines = 32'h8000_0000; irqEnable = 32'h8000_0000; globalEnable = 1'b1;
    pulseFault(0);
    chk("R5 regular before nmi", int'(reqCode), 31);
    step(1);
    chk("R5 nmi wins", int'(reqCode), 128);
    globalEnable = 1'b0;
    step(2);
    chk("R5 global does not mask", int'(reqValid), 1);
  endtask

  task automatic tDebug();
    doReset();
    irqLines = 32'h0000_0008; irqEnable = 32'h0000_0008; globalEnable = 1'b1;
    debugMode = 1'b1;
    step(2);
    chk("R6 regular masked", int'(reqValid), 0);
    pulseFault(3);
    step(3);
    chk("R6 nmi masked", int'(reqValid), 0);
    chk("R11 flag while masked", int'(nmiPending), 1);
    debugMode = 1'b0;
    step(1);
    chk("R6 nmi after exit valid", int'(reqValid), 1);
    chk("R6 nmi after exit code", int'(reqCode), 131);
  endtask

  task automatic tStep();
    doReset();
    irqLines = 32'h0000_0800; irqEnable = 32'h0000_0800; globalEnable = 1'b1;
    singleStep = 1'b1; stepIrqEnable = 1'b0;
    pulseFault(2);
    step(2);
    chk("R7 regular not masked", int'(reqCode), 11);
    stepIrqEnable = 1'b1;
    step(1);
    chk("R7 step enable shows nmi", int'(reqCode), 130);
  endtask

  task automatic tFirstFault();
    doReset();
    pulseFault(0);
    pulseFault(3);
    pulseFault(1);
    step(1);
    chk("R8 first fault kept", int'(reqCode), 128);
  endtask

  task automatic tAck();
    doReset();
    pulseFault(1);
    step(1);
    chk("R9 presented", int'(reqCode), 129);
    trapTaken = 1'b1; step(1); trapTaken = 1'b0;
    chk("R9 valid drops", int'(reqValid), 0);
    chk("R11 flag cleared", int'(nmiPending), 0);
    pulseFault(0);
    step(1);
    chk("R9 relatch after handler", int'(reqCode), 128);
    trapTaken = 1'b1; loadParityFault = 1'b1;
    step(1);
    trapTaken = 1'b0; loadParityFault = 1'b0;
    chk("R9 same cycle flag", int'(nmiPending), 1);
    chk("R9 same cycle gap", int'(reqValid), 0);
    step(1);
    chk("R9 same cycle code", int'(reqCode), 130);
  endtask

  task automatic tSimultaneous();
    doReset();
    dataErr = 1'b1; dataRvalid = 1'b1; accessIsStore = 1'b1; loadParityFault = 1'b1;
    step(1);
    dataErr = 1'b0; dataRvalid = 1'b0; accessIsStore = 1'b0; loadParityFault = 1'b0;
    step(1);
    chk("R12 highest simultaneous", int'(reqCode), 130);
  endtask

  initial begin
    tResetState();
    tGating();
    tReserved();
    tPriority();
    tNmiCodes();
    tNmiOverRegular();
    tDebug();
    tStep();
    tFirstFault();
    tAck();
    tSimultaneous();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule